// File: doc/BRIEF.md
# Precise Exception Commit Controller

This block decides, at the last stage of a five-stage in-order pipeline, whether the instruction leaving writeback is allowed to change architectural state. A fault raised anywhere along the pipe travels with its instruction as a request flag and a cause code. The fault is only acted on once that instruction is the oldest one in flight, at writeback. In that cycle the controller squashes every younger valid stage and vetoes the faulting instruction's register write. It then either sends fetch to a fixed handler address and records the faulting PC and cause, or it parks the pipeline until a cache refill completes and then refetches the faulting instruction itself.

The block also holds the execute-stage adder for trapping additions. The sum always wraps modulo 2^XLEN. A separate flag marks signed overflow when the operation is a trapping add. That flag is what the pipeline carries forward as an overflow fault. Branch redirects, which are resolved in decode, pass through the controller and lose to any exception or restart redirect.

Top module: `exc_commit_ctrl`

## Requirements
- R1: After reset, `epc` and `cause` are 0, and `fetch_hold`, `redir_vld`, `rf_we` and `kill` are 0 while no stage is valid.
- R2: `ex_sum` equals `(ex_op_a + ex_op_b) mod 2^32` in every cycle, whatever `ex_trap_add` is; 3000000000 + 3000000000 gives 1705032704.
- R3: `ex_ovf` is 1 exactly when `ex_trap_add` is 1, both operands have the same sign bit, and the sum's sign bit differs from it; otherwise `ex_ovf` is 0.
- R4: A fault is taken when `stg_vld[4]` (bit 4 = writeback, bit 0 = fetch) and `wb_exc` are both 1 and `fetch_hold` is 0. In that cycle `kill[i]` equals `stg_vld[i]` for i = 0..3; in every other cycle `kill` is 0.
- R5: `rf_we` equals `stg_vld[4] & wb_rf_we`, except that it is 0 in a cycle where a fault is taken and in every cycle where `fetch_hold` is 1.
- R6: A taken fault whose cause is neither 1 nor 2 drives `redir_vld`=1 and `redir_pc`=`HANDLER_PC` in that same cycle. At the next edge `epc` is loaded with `wb_pc` and `cause` with `wb_cause`.
- R7: A taken fault with cause 1 (instruction-miss restart) or 2 (data-miss restart) leaves `epc` and `cause` unchanged and gives no redirect in the take cycle. `fetch_hold` is 1 from the next cycle on.
- R8: While `fetch_hold` is 1, `redir_vld` equals `refill_done`, and `redir_pc` is then the PC of the faulting instruction. `fetch_hold` falls in the cycle after that redirect.
- R9: With no fault taken and `fetch_hold` at 0, `redir_vld`/`redir_pc` follow `dec_br_vld`/`dec_br_pc`. A taken fault or a held pipeline overrides the decode branch. `redir_pc` is 0 whenever `redir_vld` is 0.
- R10: While `fetch_hold` is 1, a `wb_exc` at writeback is ignored: `kill` stays 0, and `epc`, `cause` and the restart PC are not changed.
- R11: A `wb_exc` with `stg_vld[4]` at 0 has no effect: no kill, no redirect from it, and no register update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stg_vld | input | 5 | Valid bit per stage, bit 4 writeback, bit 0 fetch |
| wb_exc | input | 1 | Fault request carried by the writeback instruction |
| wb_cause | input | 4 | Cause code of the writeback instruction |
| wb_pc | input | 32 | PC of the writeback instruction |
| wb_rf_we | input | 1 | Register write intent of the writeback instruction |
| refill_done | input | 1 | Cache refill finished; releases a parked restart |
| dec_br_vld | input | 1 | Branch/jump redirect request from decode |
| dec_br_pc | input | 32 | Branch/jump target from decode |
| ex_op_a | input | 32 | Execute adder operand A |
| ex_op_b | input | 32 | Execute adder operand B |
| ex_trap_add | input | 1 | Execute operation is a trapping add |
| ex_sum | output | 32 | Wrapping sum |
| ex_ovf | output | 1 | Signed overflow on a trapping add |
| kill | output | 4 | Invalidate mask for stages 0..3 |
| rf_we | output | 1 | Qualified register-file write enable |
| redir_vld | output | 1 | Fetch redirect valid |
| redir_pc | output | 32 | Fetch redirect target |
| fetch_hold | output | 1 | Pipeline parked, waiting for refill |
| epc | output | 32 | Recorded faulting PC |
| cause | output | 4 | Recorded fault cause |

## Verification
The assertions assume that the pipeline clears the stages named in `kill` and keeps fetch stalled while `fetch_hold` is high. They also assume that `wb_pc` and `wb_cause` are stable whenever `stg_vld[4]` and `wb_exc` are both high. The stimulus drives every input afresh each cycle from a seeded generator. It raises faults at writeback with a low probability, and it draws cause codes over 0..3 so that both handler and restart paths occur. Refill completion is random, so the parked state lasts for varying lengths. Because the bench checks against its own model rather than a real pipeline, it also deliberately sends faults while the pipeline is parked and while writeback is invalid, and it checks that the controller ignores them.

// File: rtl/exc_pkg.sv
package exc_pkg;
   localparam int unsigned CODE_OVF   = 0;
   localparam int unsigned CODE_IMISS = 1;
   localparam int unsigned CODE_DMISS = 2;

   typedef enum logic {
      ST_RUN  = 1'b0,
      ST_PARK = 1'b1
   } park_state_e;

   function automatic logic code_is_restart(input int unsigned code);
      return (code == CODE_IMISS) || (code == CODE_DMISS);
   endfunction
endpackage

// File: rtl/exc_ovf_add.sv
module exc_ovf_add #(
   parameter int unsigned XLEN      = 32,
   parameter bit          CHECK_OVF = 1'b1
) (
   input  logic [XLEN-1:0] op_a,
   input  logic [XLEN-1:0] op_b,
   input  logic            trap_add,
   output logic [XLEN-1:0] sum,
   output logic            ovf
);
   localparam int unsigned MSB = XLEN - 1;

   assign sum = op_a + op_b;

   generate
      if (CHECK_OVF) begin : g_ovf_on
         logic same_sign;
         logic sign_flip;
         assign same_sign = ~(op_a[MSB] ^ op_b[MSB]);
         assign sign_flip = sum[MSB] ^ op_a[MSB];
         assign ovf = trap_add & same_sign & sign_flip;
      end else begin : g_ovf_off
         assign ovf = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/exc_take_logic.sv
module exc_take_logic #(
   parameter int unsigned NSTG    = 5,
   parameter int unsigned CAUSE_W = 4
) (
   input  logic [NSTG-1:0]    stg_vld,
   input  logic               wb_exc,
   input  logic [CAUSE_W-1:0] wb_cause,
   input  logic               parked,
   output logic               take_trap,
   output logic               take_miss,
   output logic [NSTG-2:0]    kill
);
   import exc_pkg::*;
   localparam int unsigned WB = NSTG - 1;

   logic take_any;
   logic is_restart;

   assign take_any   = stg_vld[WB] & wb_exc & ~parked;
   assign is_restart = code_is_restart(int'(wb_cause));
   assign take_trap  = take_any & ~is_restart;
   assign take_miss  = take_any & is_restart;

   generate
      for (genvar s = 0; s < NSTG - 1; s++) begin : g_kill
         assign kill[s] = take_any & stg_vld[s];
      end
   endgenerate
endmodule

// File: rtl/exc_ctx_regs.sv
module exc_ctx_regs #(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned CAUSE_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               take_trap,
   input  logic               take_miss,
   input  logic               refill_done,
   input  logic [XLEN-1:0]    wb_pc,
   input  logic [CAUSE_W-1:0] wb_cause,
   output logic               parked,
   output logic               resume,
   output logic [XLEN-1:0]    restart_pc,
   output logic [XLEN-1:0]    epc_q,
   output logic [CAUSE_W-1:0] cause_q
);
   import exc_pkg::*;

   park_state_e st_q, st_d;

   assign parked = (st_q == ST_PARK);
   assign resume = parked & refill_done;

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_RUN:  if (take_miss) st_d = ST_PARK;
         ST_PARK: if (refill_done) st_d = ST_RUN;
         default: st_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_RUN;
         restart_pc <= '0;
         epc_q      <= '0;
         cause_q    <= '0;
      end else begin
         st_q <= st_d;
         if (take_miss) restart_pc <= wb_pc;
         if (take_trap) begin
            epc_q   <= wb_pc;
            cause_q <= wb_cause;
         end
      end
   end
endmodule

// File: rtl/exc_commit_ctrl.sv
module exc_commit_ctrl #(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned NSTG       = 5,
   parameter int unsigned CAUSE_W    = 4,
   parameter logic [31:0] HANDLER_PC = 32'h0000_0080,
   parameter bit          CHECK_OVF  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NSTG-1:0]    stg_vld,
   input  logic               wb_exc,
   input  logic [CAUSE_W-1:0] wb_cause,
   input  logic [XLEN-1:0]    wb_pc,
   input  logic               wb_rf_we,
   input  logic               refill_done,
   input  logic               dec_br_vld,
   input  logic [XLEN-1:0]    dec_br_pc,
   input  logic [XLEN-1:0]    ex_op_a,
   input  logic [XLEN-1:0]    ex_op_b,
   input  logic               ex_trap_add,
   output logic [XLEN-1:0]    ex_sum,
   output logic               ex_ovf,
   output logic [NSTG-2:0]    kill,
   output logic               rf_we,
   output logic               redir_vld,
   output logic [XLEN-1:0]    redir_pc,
   output logic               fetch_hold,
   output logic [XLEN-1:0]    epc,
   output logic [CAUSE_W-1:0] cause
);
   localparam int unsigned WB = NSTG - 1;
   localparam logic [XLEN-1:0] HANDLER_X = XLEN'(HANDLER_PC);

   generate
      if (NSTG < 3) begin : g_bad_nstg
         $error("exc_commit_ctrl: NSTG must be at least 3");
      end
      if (XLEN < 8) begin : g_bad_xlen
         $error("exc_commit_ctrl: XLEN must be at least 8");
      end
      if (CAUSE_W < 2) begin : g_bad_cw
         $error("exc_commit_ctrl: CAUSE_W must hold codes 0..2");
      end
   endgenerate

   logic            take_trap;
   logic            take_miss;
   logic            parked;
   logic            resume;
   logic [XLEN-1:0] restart_pc;

   exc_ovf_add #(.XLEN(XLEN), .CHECK_OVF(CHECK_OVF)) u_add (
      .op_a     (ex_op_a),
      .op_b     (ex_op_b),
      .trap_add (ex_trap_add),
      .sum      (ex_sum),
      .ovf      (ex_ovf)
   );

   exc_take_logic #(.NSTG(NSTG), .CAUSE_W(CAUSE_W)) u_take (
      .stg_vld   (stg_vld),
      .wb_exc    (wb_exc),
      .wb_cause  (wb_cause),
      .parked    (parked),
      .take_trap (take_trap),
      .take_miss (take_miss),
      .kill      (kill)
   );

   exc_ctx_regs #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_ctx (
      .clk         (clk),
      .rst_n       (rst_n),
      .take_trap   (take_trap),
      .take_miss   (take_miss),
      .refill_done (refill_done),
      .wb_pc       (wb_pc),
      .wb_cause    (wb_cause),
      .parked      (parked),
      .resume      (resume),
      .restart_pc  (restart_pc),
      .epc_q       (epc),
      .cause_q     (cause)
   );

   assign fetch_hold = parked;
   assign rf_we      = stg_vld[WB] & wb_rf_we & ~take_trap & ~take_miss & ~parked;

   always_comb begin
      redir_vld = 1'b0;
      redir_pc  = '0;
      if (take_trap) begin
         redir_vld = 1'b1;
         redir_pc  = HANDLER_X;
      end else if (resume) begin
         redir_vld = 1'b1;
         redir_pc  = restart_pc;
      end else if (!take_miss && !parked && dec_br_vld) begin
         redir_vld = 1'b1;
         redir_pc  = dec_br_pc;
      end
   end
endmodule

// File: rtl/exc_commit_ctrl_chk.sv
module exc_commit_ctrl_chk #(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned NSTG       = 5,
   parameter int unsigned CAUSE_W    = 4,
   parameter logic [31:0] HANDLER_PC = 32'h0000_0080
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NSTG-1:0]    stg_vld,
   input logic               wb_exc,
   input logic [CAUSE_W-1:0] wb_cause,
   input logic [XLEN-1:0]    wb_pc,
   input logic               refill_done,
   input logic               ex_trap_add,
   input logic               ex_ovf,
   input logic [NSTG-2:0]    kill,
   input logic               rf_we,
   input logic               redir_vld,
   input logic [XLEN-1:0]    redir_pc,
   input logic               fetch_hold,
   input logic [XLEN-1:0]    epc,
   input logic [CAUSE_W-1:0] cause
);
   localparam int unsigned WB = NSTG - 1;

   logic fault_at_wb;
   logic restart_code;
   assign fault_at_wb  = stg_vld[WB] & wb_exc & ~fetch_hold;
   assign restart_code = (wb_cause == CAUSE_W'(1)) || (wb_cause == CAUSE_W'(2));

   assert_ovf_needs_trap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ex_ovf |-> ex_trap_add);

   assert_kill_younger_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fault_at_wb |-> (kill == stg_vld[NSTG-2:0]));

   assert_no_kill_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_at_wb |-> (kill == '0));

   assert_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_at_wb || fetch_hold) |-> !rf_we);

   assert_epc_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_at_wb && !restart_code) |=> (epc == $past(wb_pc)) && (cause == $past(wb_cause)));

   assert_miss_parks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_at_wb && restart_code) |=> fetch_hold && $stable(epc) && $stable(cause));

   assert_park_waits_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_hold |-> (redir_vld == refill_done));

   assert_unpark_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_hold && refill_done) |=> !fetch_hold);

   assert_idle_pc_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !redir_vld |-> (redir_pc == '0));

   assert_park_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_hold |=> $stable(epc) && $stable(cause));
endmodule

bind exc_commit_ctrl exc_commit_ctrl_chk #(
   .XLEN(XLEN), .NSTG(NSTG), .CAUSE_W(CAUSE_W), .HANDLER_PC(HANDLER_PC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .stg_vld(stg_vld), .wb_exc(wb_exc),
   .wb_cause(wb_cause), .wb_pc(wb_pc), .refill_done(refill_done),
   .ex_trap_add(ex_trap_add), .ex_ovf(ex_ovf), .kill(kill), .rf_we(rf_we),
   .redir_vld(redir_vld), .redir_pc(redir_pc), .fetch_hold(fetch_hold),
   .epc(epc), .cause(cause)
);

// File: tb/exc_commit_ctrl_bench.sv
`timescale 1ns/1ps
module exc_commit_ctrl_bench;
   localparam logic [31:0] HANDLER = 32'h0000_0080;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  stg_vld = '0;
   logic        wb_exc = 1'b0;
   logic [3:0]  wb_cause = '0;
   logic [31:0] wb_pc = '0;
   logic        wb_rf_we = 1'b0;
   logic        refill_done = 1'b0;
   logic        dec_br_vld = 1'b0;
   logic [31:0] dec_br_pc = '0;
   logic [31:0] ex_op_a = '0;
   logic [31:0] ex_op_b = '0;
   logic        ex_trap_add = 1'b0;
   logic [31:0] ex_sum;
   logic        ex_ovf;
   logic [3:0]  kill;
   logic        rf_we;
   logic        redir_vld;
   logic [31:0] redir_pc;
   logic        fetch_hold;
   logic [31:0] epc;
   logic [3:0]  cause;

   exc_commit_ctrl u_exc_commit_ctrl (
      .clk(clk), .rst_n(rst_n), .stg_vld(stg_vld), .wb_exc(wb_exc),
      .wb_cause(wb_cause), .wb_pc(wb_pc), .wb_rf_we(wb_rf_we),
      .refill_done(refill_done), .dec_br_vld(dec_br_vld), .dec_br_pc(dec_br_pc),
      .ex_op_a(ex_op_a), .ex_op_b(ex_op_b), .ex_trap_add(ex_trap_add),
      .ex_sum(ex_sum), .ex_ovf(ex_ovf), .kill(kill), .rf_we(rf_we),
      .redir_vld(redir_vld), .redir_pc(redir_pc), .fetch_hold(fetch_hold),
      .epc(epc), .cause(cause)
   );

   always #4 clk = ~clk;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   // model state
   bit          m_park = 1'b0;
   logic [31:0] m_rpc = '0;
   logic [31:0] m_epc = '0;
   logic [3:0]  m_cause = '0;

   function automatic logic [31:0] exp_sum(input logic [31:0] a, input logic [31:0] b);
      logic [32:0] full;
      full = {1'b0, a} + {1'b0, b};
      return full[31:0];
   endfunction

   function automatic logic exp_ovf(input logic [31:0] a, input logic [31:0] b, input logic t);
      longint sa, sb, s;
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      s  = sa + sb;
      return t && (s > 64'sd2147483647 || s < -64'sd2147483648);
   endfunction

   task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
      end
   endtask

   // compare all outputs against the model for the current inputs, then advance the model
   task automatic check_cycle();
      bit take, miss, trap, restart_code;
      logic [3:0]  e_kill;
      logic        e_we, e_rv;
      logic [31:0] e_rpc;
      restart_code = (wb_cause == 4'd1) || (wb_cause == 4'd2);
      take = stg_vld[4] && wb_exc && !m_park;
      miss = take && restart_code;
      trap = take && !restart_code;
      e_kill = take ? stg_vld[3:0] : 4'd0;
      e_we = stg_vld[4] && wb_rf_we && !take && !m_park;
      if (trap) begin e_rv = 1'b1; e_rpc = HANDLER; end
      else if (m_park && refill_done) begin e_rv = 1'b1; e_rpc = m_rpc; end
      else if (!take && !m_park && dec_br_vld) begin e_rv = 1'b1; e_rpc = dec_br_pc; end
      else begin e_rv = 1'b0; e_rpc = '0; end
      chk("R2", "ex_sum", 64'(ex_sum), 64'(exp_sum(ex_op_a, ex_op_b)));
      chk("R3", "ex_ovf", 64'(ex_ovf), 64'(exp_ovf(ex_op_a, ex_op_b, ex_trap_add)));
      chk(stg_vld[4] ? "R4" : "R11", "kill", 64'(kill), 64'(e_kill));
      chk(m_park ? "R10" : "R5", "rf_we", 64'(rf_we), 64'(e_we));
      chk(m_park ? "R8" : "R9", "redir_vld", 64'(redir_vld), 64'(e_rv));
      chk(trap ? "R6" : "R9", "redir_pc", 64'(redir_pc), 64'(e_rpc));
      chk("R7", "fetch_hold", 64'(fetch_hold), 64'(m_park));
      chk(m_park ? "R10" : "R6", "epc", 64'(epc), 64'(m_epc));
      chk(m_park ? "R10" : "R7", "cause", 64'(cause), 64'(m_cause));
      if (trap) begin m_epc = wb_pc; m_cause = wb_cause; end
      if (m_park && refill_done) m_park = 1'b0;
      else if (miss) begin m_park = 1'b1; m_rpc = wb_pc; end
   endtask

   task automatic drive(input logic [4:0] v, input logic x, input logic [3:0] c,
                        input logic [31:0] pc, input logic we, input logic rd,
                        input logic bv, input logic [31:0] bpc);
      @(negedge clk);
      stg_vld = v; wb_exc = x; wb_cause = c; wb_pc = pc; wb_rf_we = we;
      refill_done = rd; dec_br_vld = bv; dec_br_pc = bpc;
      #1;
      check_cycle();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = 32'd20240611;
      void'($urandom(seed));
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1", "epc", 64'(epc), 64'd0);
      chk("R1", "cause", 64'(cause), 64'd0);
      chk("R1", "fetch_hold", 64'(fetch_hold), 64'd0);
      chk("R1", "redir_vld", 64'(redir_vld), 64'd0);
      chk("R1", "rf_we", 64'(rf_we), 64'd0);
      chk("R1", "kill", 64'(kill), 64'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R2/R3 directed: wrap example and sign cases
      @(negedge clk);
      ex_op_a = 32'd3000000000; ex_op_b = 32'd3000000000; ex_trap_add = 1'b0; #1;
      chk("R2", "wrap sum", 64'(ex_sum), 64'd1705032704);
      chk("R3", "ovf no trap", 64'(ex_ovf), 64'd0);
      ex_trap_add = 1'b1; #1;
      chk("R3", "ovf trap neg+neg", 64'(ex_ovf), 64'd1);
      ex_op_a = 32'h7fff_ffff; ex_op_b = 32'd1; #1;
      chk("R3", "ovf pos+pos", 64'(ex_ovf), 64'd1);
      ex_op_a = 32'h7fff_ffff; ex_op_b = 32'hffff_ffff; #1;
      chk("R3", "ovf mixed sign", 64'(ex_ovf), 64'd0);

      // R6 and R9: trap overrides decode branch
      drive(5'b11111, 1'b1, 4'd0, 32'h0000_1234, 1'b1, 1'b0, 1'b1, 32'h0000_5000);
      drive(5'b10000, 1'b0, 4'd0, 32'h0, 1'b1, 1'b0, 1'b1, 32'h0000_6000);
      // R11: invalid writeback with fault request
      drive(5'b01111, 1'b1, 4'd3, 32'h0000_9999, 1'b1, 1'b0, 1'b0, 32'h0);
      // R7 then R10 then R8: data-miss restart, fault ignored while parked, late refill
      drive(5'b10110, 1'b1, 4'd2, 32'h0000_4400, 1'b1, 1'b1, 1'b0, 32'h0);
      drive(5'b11000, 1'b1, 4'd0, 32'h0000_7700, 1'b1, 1'b0, 1'b1, 32'h0000_1000);
      drive(5'b00000, 1'b0, 4'd0, 32'h0, 1'b0, 1'b0, 1'b0, 32'h0);
      drive(5'b00000, 1'b0, 4'd0, 32'h0, 1'b0, 1'b1, 1'b1, 32'h0000_2000);
      drive(5'b10000, 1'b0, 4'd0, 32'h0, 1'b1, 1'b0, 1'b0, 32'h0);
      // instruction-miss restart with immediate refill
      drive(5'b11111, 1'b1, 4'd1, 32'h0000_0c00, 1'b0, 1'b0, 1'b0, 32'h0);
      drive(5'b00000, 1'b0, 4'd0, 32'h0, 1'b0, 1'b1, 1'b0, 32'h0);

      // constrained random
      for (int i = 0; i < 4000; i++) begin
         logic [4:0] v;
         logic x;
         v = 5'($urandom);
         x = ($urandom % 6) == 0;
         ex_op_a = $urandom; ex_op_b = $urandom;
         if (($urandom % 4) == 0) ex_op_b = ex_op_a;
         ex_trap_add = 1'($urandom);
         drive(v, x, 4'($urandom % 4), {$urandom} & 32'hffff_fffc, 1'($urandom),
               ($urandom % 4) == 0, 1'($urandom), {$urandom} & 32'hffff_fffc);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule